// File: doc/BRIEF.md
# Code Block Input Admission Controller

This block sits in front of a block-based decoder and decides whether a new code block may enter. It watches an enabled-sample stream, recognises the start marker that accompanies the first enabled sample of a block, and counts the enabled samples of the admitted block against the programmed length in pairs. When the count reaches that length it emits a single-cycle completion pulse.

Admission is tracked in two independent ready flags. Blocks whose length is one of the large multiples of 480 pairs (480 up to 2400) use one flag, and every other length uses the other. A flag drops when its class is admitted and comes back when downstream returns a release strobe for that class. A start marker that arrives while the flag for its class is low is refused and sets a sticky overflow flag. Enabled samples that arrive with no block open and no start marker are discarded and tallied in a saturating counter.

Top module: `blk_admit_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets synchronously: `rdy` becomes 2'b11, and `ovf`, `busy`, `blk_done` and `stray_cnt` become zero.
- R2: Only clock edges with `smp_en` high have any effect on admission, counting or the stray counter; a `smp_start` with `smp_en` low is ignored.
- R3: A block whose length `blk_len` equals 480, 960, 1440, 1920 or 2400 belongs to the large class and is governed by `rdy[1]`; every other length, including 481 and 2880, is governed by `rdy[0]`.
- R4: A start accepted while idle clears the ready bit of its class at that edge. A `free_big` strobe sets `rdy[1]` and a `free_small` strobe sets `rdy[0]` at the next edge. When an admission and a release of the same class share an edge, the bit ends low.
- R5: An enabled start while idle whose class ready bit is low raises `ovf` at that edge, does not open a block, and leaves both ready bits unchanged.
- R6: Once `ovf` is high it stays high until reset, whatever the other inputs do.
- R7: The start sample counts as the first of the block. `blk_done` is high for exactly one cycle after the edge that captures the `blk_len`-th enabled sample, and `busy` falls at that same edge. A length of 0 or 1 completes on the start sample itself, and `busy` never rises.
- R8: While a block is open, a `smp_start` that comes with an enabled sample is not a new start. The sample counts toward the open block, and neither `ovf` nor `rdy` changes.
- R9: An enabled sample with no block open and no start marker adds one to `stray_cnt`. The counter saturates at 2^CNT_W-1, which is 15 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| blk_len | input | LEN_W (12) | Programmed block length in pairs, sampled on the start edge |
| smp_en | input | 1 | Enable that qualifies an input sample |
| smp_start | input | 1 | Start marker, valid together with the first enabled sample |
| free_big | input | 1 | Release strobe from downstream for the large class |
| free_small | input | 1 | Release strobe from downstream for the other class |
| rdy | output | 2 | Ready flags: bit 1 for the large class, bit 0 for the other class |
| ovf | output | 1 | Sticky flag for a start refused while its class was not ready |
| busy | output | 1 | A block is open and still collecting samples |
| blk_done | output | 1 | One-cycle pulse after the last sample of a block |
| stray_cnt | output | CNT_W (4) | Saturating count of enabled samples that arrived outside a block |

## Verification
The bench goes after length classification at its edges. A neighbour of a large length such as 481, or a multiple beyond the set such as 2880, that landed in the large class would drop the wrong ready bit. It also hits the same-edge release and admission case, where a design that gives priority to the release would leave the class ready when it is in fact full. A start marker in the middle of a block is sent too; a design that treats it as a new start would restart the count or raise overflow. The bench also covers one-pair blocks, which must pulse completion without ever raising busy, and a long run of stray samples, where a design that wraps the counter instead of holding it would read back near zero.

// File: rtl/admit_pkg.sv
// Package: shared types for the code block admission controller.
// Assumes: nothing beyond the standard; consumed by every admit_* module.
package admit_pkg;
    // Block size class; the numeric value doubles as the index into the ready vector.
    typedef enum logic {
        CLS_SMALL = 1'b0,
        CLS_BIG   = 1'b1
    } blk_cls_e;

    localparam int unsigned NUM_CLS = 2;
endpackage

// File: rtl/admit_size_class.sv
// Module: admit_size_class
// Classifies a programmed block length into the large class (an exact
// multiple BIG_STEP*k, k = 1..BIG_NUM) or the small class (everything else).
// Assumes: BIG_NUM*BIG_STEP fits in LEN_W bits. Purely combinational.
module admit_size_class
    import admit_pkg::*;
#(
    parameter int unsigned LEN_W    = 12,
    parameter int unsigned BIG_STEP = 480,
    parameter int unsigned BIG_NUM  = 5
) (
    input  logic [LEN_W-1:0] blk_len,
    output blk_cls_e         cls
);
    logic [BIG_NUM-1:0] hit;

    // One comparator per member of the large-length set.
    for (genvar k = 0; k < BIG_NUM; k++) begin : g_cmp
        localparam logic [LEN_W-1:0] LenK = LEN_W'((k + 1) * BIG_STEP);
        assign hit[k] = (blk_len == LenK);
    end

    // Any comparator match selects the large class.
    always_comb begin
        cls = (|hit) ? CLS_BIG : CLS_SMALL;
    end
endmodule

// File: rtl/admit_ready_ctl.sv
// Module: admit_ready_ctl
// Holds one ready flag per size class. A flag clears when its class is
// admitted and sets again on the matching release strobe; the clear wins
// when both land on the same edge.
// Assumes: adm is at most one-hot and only asserted while its flag is set.
module admit_ready_ctl
    import admit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLS-1:0] adm,
    input  logic [NUM_CLS-1:0] rel,
    output logic [NUM_CLS-1:0] rdy
);
    for (genvar i = 0; i < NUM_CLS; i++) begin : g_flag
        // Per-class ready flag: reset high, clear on admit, set on release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdy[i] <= 1'b1;
            end else if (adm[i]) begin
                rdy[i] <= 1'b0;
            end else if (rel[i]) begin
                rdy[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/admit_seq.sv
// Module: admit_seq
// Admission sequencer: decides on each enabled start whether a block opens
// or is refused, counts enabled samples of the open block, pulses done on
// the last one, raises the sticky overflow flag and tallies stray samples.
// Assumes: blk_len is stable on the start edge (it is latched there);
// cls is the classification of the current blk_len.
module admit_seq
    import admit_pkg::*;
#(
    parameter int unsigned LEN_W = 12,
    parameter int unsigned CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_en,
    input  logic               smp_start,
    input  logic [LEN_W-1:0]   blk_len,
    input  blk_cls_e           cls,
    input  logic [NUM_CLS-1:0] rdy,
    output logic [NUM_CLS-1:0] adm,
    output logic               busy,
    output logic               blk_done,
    output logic               ovf,
    output logic [CNT_W-1:0]   stray_cnt
);
    localparam logic [CNT_W-1:0] StrayMax = '1;

    logic               start_idle;
    logic               cls_ready;
    logic               admit;
    logic               refuse;
    logic               stray;
    logic               short_blk;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   cnt_q;
    logic [LEN_W:0]     cnt_nxt;

    // Decode the current edge: start from idle, and its outcome.
    always_comb begin
        start_idle = smp_en && smp_start && !busy;
        cls_ready  = rdy[cls];
        admit      = start_idle && cls_ready;
        refuse     = start_idle && !cls_ready;
        stray      = smp_en && !smp_start && !busy;
        short_blk  = (blk_len <= LEN_W'(1));
        cnt_nxt    = {1'b0, cnt_q} + 1'b1;
        adm        = '0;
        adm[cls]   = admit;
    end

    // Block state: open on admit, count enabled samples, close on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            blk_done <= 1'b0;
            cnt_q    <= '0;
            len_q    <= '0;
        end else begin
            blk_done <= 1'b0;
            if (admit) begin
                len_q <= blk_len;
                cnt_q <= LEN_W'(1);
                if (short_blk) begin
                    blk_done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy && smp_en) begin
                cnt_q <= cnt_nxt[LEN_W-1:0];
                if (cnt_nxt >= {1'b0, len_q}) begin
                    busy     <= 1'b0;
                    blk_done <= 1'b1;
                end
            end
        end
    end

    // Sticky overflow: set by a refused start, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (refuse) begin
            ovf <= 1'b1;
        end
    end

    // Saturating tally of enabled samples seen outside any block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stray_cnt <= '0;
        end else if (stray && (stray_cnt != StrayMax)) begin
            stray_cnt <= stray_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/blk_admit_ctrl.sv
// Module: blk_admit_ctrl (top)
// Code block input admission controller: classifies the programmed length,
// keeps per-class ready flags, sequences block admission and counting.
// Assumes: synchronous active-low reset; release strobes come from the
// downstream consumer once a buffer of that class is free.
module blk_admit_ctrl
    import admit_pkg::*;
#(
    parameter int unsigned LEN_W    = 12,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned BIG_STEP = 480,
    parameter int unsigned BIG_NUM  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             smp_en,
    input  logic             smp_start,
    input  logic             free_big,
    input  logic             free_small,
    output logic [1:0]       rdy,
    output logic             ovf,
    output logic             busy,
    output logic             blk_done,
    output logic [CNT_W-1:0] stray_cnt
);
    blk_cls_e           cls;
    logic               is_big;
    logic [NUM_CLS-1:0] adm;
    logic [NUM_CLS-1:0] rel;

    // Map the release strobes onto class indices.
    always_comb begin
        rel            = '0;
        rel[CLS_BIG]   = free_big;
        rel[CLS_SMALL] = free_small;
        is_big         = (cls == CLS_BIG);
    end

    admit_size_class #(
        .LEN_W   (LEN_W),
        .BIG_STEP(BIG_STEP),
        .BIG_NUM (BIG_NUM)
    ) i_class (
        .blk_len(blk_len),
        .cls    (cls)
    );

    admit_ready_ctl i_ready (
        .clk  (clk),
        .rst_n(rst_n),
        .adm  (adm),
        .rel  (rel),
        .rdy  (rdy)
    );

    admit_seq #(
        .LEN_W(LEN_W),
        .CNT_W(CNT_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .smp_start(smp_start),
        .blk_len  (blk_len),
        .cls      (cls),
        .rdy      (rdy),
        .adm      (adm),
        .busy     (busy),
        .blk_done (blk_done),
        .ovf      (ovf),
        .stray_cnt(stray_cnt)
    );
endmodule

// File: rtl/admit_ctrl_chk.sv
// Module: admit_ctrl_chk
// Property checker for blk_admit_ctrl, attached through bind below.
// Assumes: is_big is the classifier result from inside the top module.
module admit_ctrl_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_en,
    input logic             smp_start,
    input logic             free_big,
    input logic             free_small,
    input logic             is_big,
    input logic [1:0]       rdy,
    input logic             ovf,
    input logic             busy,
    input logic             blk_done,
    input logic [CNT_W-1:0] stray_cnt
);
    localparam logic [CNT_W-1:0] StrayMax = '1;

    // R4: admitting a large block drops rdy[1].
    a_r4_big_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && smp_start && !busy && is_big && rdy[1]) |=> !rdy[1]);

    // R4: admitting a small block drops rdy[0].
    a_r4_small_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && smp_start && !busy && !is_big && rdy[0]) |=> !rdy[0]);

    // R4: a ready bit only rises after its release strobe.
    a_r4_big_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy[1]) |-> $past(free_big));

    a_r4_small_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy[0]) |-> $past(free_small));

    // R5: a start refused for lack of readiness raises overflow and opens nothing.
    a_r5_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && smp_start && !busy && !(is_big ? rdy[1] : rdy[0]))
        |=> (ovf && !busy));

    // R6: overflow is sticky.
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R7: completion is never reported while a block is still open.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> !busy);

    // R2: without an enabled sample an idle block stays idle and the tally holds.
    a_r2_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_en && !busy) |=> (!busy && !blk_done && $stable(stray_cnt)));

    // R9: the stray tally holds once saturated.
    a_r9_stray_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (stray_cnt == StrayMax) |=> (stray_cnt == StrayMax));
endmodule

bind blk_admit_ctrl admit_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .smp_start (smp_start),
    .free_big  (free_big),
    .free_small(free_small),
    .is_big    (is_big),
    .rdy       (rdy),
    .ovf       (ovf),
    .busy      (busy),
    .blk_done  (blk_done),
    .stray_cnt (stray_cnt)
);

// File: tb/test_blk_admit_ctrl.sv
// Bench for blk_admit_ctrl: behavioural reference model compared every
// clock, plus directed checks at the corner cases.
`timescale 1ns/100ps
module test_blk_admit_ctrl;
    localparam int LEN_W = 12;
    localparam int CNT_W = 4;
    localparam int STRAY_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] blk_len = '0;
    logic             smp_en = 1'b0;
    logic             smp_start = 1'b0;
    logic             free_big = 1'b0;
    logic             free_small = 1'b0;
    logic [1:0]       rdy;
    logic             ovf;
    logic             busy;
    logic             blk_done;
    logic [CNT_W-1:0] stray_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;

    // Reference model state.
    bit [1:0] m_rdy = 2'b11;
    bit       m_ovf = 0;
    bit       m_busy = 0;
    bit       m_done = 0;
    int       m_cnt = 0;
    int       m_len = 0;
    int       m_stray = 0;

    always #2.5 clk = ~clk;

    blk_admit_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_blk_admit_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_len   (blk_len),
        .smp_en    (smp_en),
        .smp_start (smp_start),
        .free_big  (free_big),
        .free_small(free_small),
        .rdy       (rdy),
        .ovf       (ovf),
        .busy      (busy),
        .blk_done  (blk_done),
        .stray_cnt (stray_cnt)
    );

    function automatic int big_len(input int len);
        return (len >= 480 && len <= 2400 && (len % 480) == 0) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        n_cyc++;
        if (!rst_n) begin
            m_rdy = 2'b11; m_ovf = 0; m_busy = 0; m_done = 0;
            m_cnt = 0; m_len = 0; m_stray = 0;
        end else begin
            bit [1:0] old_rdy;
            int cls;
            bit nd;
            nd = 0;
            old_rdy = m_rdy;
            cls = big_len(int'(blk_len));
            m_rdy[1] = m_rdy[1] | free_big;
            m_rdy[0] = m_rdy[0] | free_small;
            if (smp_en) begin
                if (m_busy) begin
                    m_cnt++;
                    if (m_cnt >= m_len) begin m_busy = 0; nd = 1; end
                end else if (smp_start) begin
                    if (old_rdy[cls]) begin
                        m_rdy[cls] = 0;
                        m_cnt = 1;
                        m_len = int'(blk_len);
                        if (m_len <= 1) nd = 1;
                        else m_busy = 1;
                    end else begin
                        m_ovf = 1;
                    end
                end else if (m_stray < STRAY_MAX) begin
                    m_stray++;
                end
            end
            m_done = nd;
        end
    end

    // Cycle-by-cycle comparison, away from the edge.
    always @(posedge clk) begin
        #1;
        chk("R3/R4 rdy", int'(rdy), int'(m_rdy));
        chk("R5/R6 ovf", int'(ovf), int'(m_ovf));
        chk("R8 busy", int'(busy), int'(m_busy));
        chk("R7 blk_done", int'(blk_done), int'(m_done));
        chk("R9 stray_cnt", int'(stray_cnt), m_stray);
    end

    // Drive one cycle of inputs at the falling edge.
    task automatic cyc(input bit en, input bit st, input bit fb, input bit fs, input int len);
        @(negedge clk);
        smp_en = en; smp_start = st; free_big = fb; free_small = fs;
        blk_len = LEN_W'(len);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, int'(blk_len));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        smp_en = 0; smp_start = 0; free_big = 0; free_small = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int fed;
        do_reset();
        idle();
        // R1: reset values.
        chk("R1 rdy", int'(rdy), 3);
        chk("R1 ovf", int'(ovf), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 stray", int'(stray_cnt), 0);

        // R9: stray samples saturate.
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 5);
        idle(); idle();
        chk("R9 stray saturated", int'(stray_cnt), STRAY_MAX);

        // Small block of 5 with gaps and a mid-block marker.
        cyc(1, 1, 0, 0, 5); idle();
        chk("R4 small clear", int'(rdy), 2);
        chk("R8 busy after start", int'(busy), 1);
        cyc(1, 0, 0, 0, 5); idle();
        cyc(1, 1, 0, 0, 5); idle();
        chk("R8 mid marker no ovf", int'(ovf), 0);
        chk("R8 mid marker still busy", int'(busy), 1);
        cyc(1, 0, 0, 0, 5);
        cyc(1, 0, 0, 0, 5);
        idle();
        chk("R7 done pulse", int'(blk_done), 1);
        chk("R7 busy fell", int'(busy), 0);
        idle();
        chk("R7 done one cycle", int'(blk_done), 0);

        // R2: start without enable is ignored.
        cyc(0, 1, 0, 0, 5); idle();
        chk("R2 no open", int'(busy), 0);
        chk("R2 no ovf", int'(ovf), 0);

        // R4: release, then release and admit on one edge (length 1).
        cyc(0, 0, 0, 1, 5); idle();
        chk("R4 release small", int'(rdy), 3);
        cyc(1, 1, 0, 1, 1); idle();
        chk("R4 same-edge clear wins", int'(rdy), 2);
        chk("R7 length one done", int'(blk_done), 1);
        chk("R7 length one never busy", int'(busy), 0);
        cyc(0, 0, 0, 1, 0); idle();

        // R7: length zero completes on the start sample.
        cyc(1, 1, 0, 0, 0); idle();
        chk("R7 length zero done", int'(blk_done), 1);
        cyc(0, 0, 0, 1, 0); idle();

        // R3: large block of 480 uses rdy[1].
        cyc(1, 1, 0, 0, 480); idle();
        chk("R3 480 large class", int'(rdy), 1);
        fed = 1;
        for (int i = 0; fed < 480; i++) begin
            if (i % 4 == 3) idle();
            else begin cyc(1, 0, 0, 0, 480); fed++; end
        end
        idle();
        chk("R7 480 done", int'(blk_done), 1);

        // R5: large start while rdy[1] low is refused.
        cyc(1, 1, 0, 0, 2400); idle();
        chk("R5 ovf set", int'(ovf), 1);
        chk("R5 no open", int'(busy), 0);
        chk("R5 rdy unchanged", int'(rdy), 1);

        // R6: overflow survives releases and traffic.
        cyc(0, 0, 1, 1, 2400);
        cyc(1, 0, 0, 0, 2400);
        idle(); idle();
        chk("R6 ovf sticky", int'(ovf), 1);
        chk("R4 release big", int'(rdy), 3);

        // R3: 481 is small class.
        cyc(1, 1, 0, 0, 481); idle();
        chk("R3 481 small class", int'(rdy), 2);

        // R6: reset clears overflow.
        do_reset(); idle();
        chk("R6 ovf cleared by reset", int'(ovf), 0);
        chk("R1 rdy after reset", int'(rdy), 3);

        // R3: 2880 small, 1920 large.
        cyc(1, 1, 0, 0, 2880); idle();
        chk("R3 2880 small class", int'(rdy), 2);
        do_reset(); idle();
        cyc(1, 1, 0, 0, 1920); idle();
        chk("R3 1920 large class", int'(rdy), 1);
        idle(); idle();
        finish_run();
    end
endmodule